// File: doc/BRIEF.md
# Sixteen-Bit Compare-Match PWM Channel

This block is one pulse-width channel built around a free-running timebase counter, 16 bits wide by default. The counter steps by one on each clock cycle in which a clock-enable strobe is high and rolls from all ones back to zero. The channel holds a compare value. When the counter steps onto that value, the output rises. When the counter rolls over, the output falls. The compare value therefore sets how many timebase ticks of each period the output spends low, and the duty cycle is (2^W − compare) / 2^W.

Software loads the compare value one byte at a time through a byte-wide write port. A low-byte write turns the comparator off and a high-byte write turns it back on, so a half-written value never produces a match: software writes the low byte first. A mode register holds the comparator enable, the PWM and wide-mode selects, and two enables for the match interrupt. A sticky match flag lets software time its compare updates to the period. Clearing the comparator enable gives a 0% duty cycle.

Top module: `pwm16_channel`

## Requirements
- R1: After reset, the timebase reads 0. The output, the match flag, the comparator enable and the interrupt are all 0, and every mode bit is 0.
- R2: The timebase advances by exactly one on each clock edge where `tick_en` is high. It holds its value on every other edge. It wraps from 2^TB_W−1 to 0.
- R3: When the channel is active and the timebase steps onto the compare value, `pwm_out` goes high on that same edge.
- R4: When the timebase wraps, `pwm_out` goes low on that edge. If a match happens on the same edge (compare value 0), the match wins and the output stays high. With no match and no wrap, the output holds.
- R5: In every full period that starts after the compare value is loaded, `pwm_out` is high for exactly 2^TB_W − compare ticks. A compare of 0 gives the whole period, and a compare of all ones gives one tick.
- R6: The channel is active only when bit 0 (comparator enable), bit 1 (PWM select) and bit 2 (wide select) of the mode register (address 2) are all 1. If bit 1 or bit 2 is 0, the channel makes no match, raises no flag, and the output stays low.
- R7: A write to address 0 loads compare bits 7:0 and clears the comparator enable. A write to address 1 loads compare bits TB_W−1:8 from the low data bits and sets the comparator enable. A write to address 2 loads all five mode bits.
- R8: If software clears the comparator enable with a lone low-byte write, the output stays low for the whole of every following period (0% duty).
- R9: Every match sets `match_flag`, and the flag stays set until software writes address 3 with data bit 0 equal to 0. Writing address 3 with bit 0 equal to 1 leaves the flag unchanged. If a match and a clear write land on the same edge, the flag stays set.
- R10: `match_irq` is high exactly when `match_flag` is set, mode bit 3 (match enable) is set, and mode bit 4 (interrupt enable) is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase clock-enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 compare low, 1 compare high, 2 mode, 3 flag |
| wr_data | input | 8 | Write data byte |
| timebase | output | TB_W | Current timebase count |
| pwm_out | output | 1 | PWM output |
| match_flag | output | 1 | Sticky match flag |
| cmp_enabled | output | 1 | Comparator enable bit |
| match_irq | output | 1 | Match interrupt request |

## Verification
The compare value is swept over 0, 1, mid-scale, a value near the top, and all ones. The high time of each whole period is then measured against 2^W − compare. Value 0 separates match-wins-at-wrap from overflow-wins. All ones separates a one-tick pulse from an off-by-one that lasts zero or two ticks. Three periods with the comparator off, the PWM select off, or the wide select off must each show no high time. This tells the enable gating apart from the mode gating. The flag is cleared on the very edge a match sets it, and the interrupt is tried under each combination of its two enables.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;

  typedef enum logic [1:0] {
    REG_CMP_LO = 2'd0,
    REG_CMP_HI = 2'd1,
    REG_MODE   = 2'd2,
    REG_FLAG   = 2'd3
  } reg_sel_e;

  // mode register, bit 0 is the comparator enable
  typedef struct packed {
    logic irq_en;    // bit 4
    logic match_en;  // bit 3
    logic wide;      // bit 2
    logic pwm;       // bit 1
    logic en;        // bit 0
  } mode_t;

  localparam int MODE_W = 5;

  function automatic logic mode_active(input mode_t m);
    return m.en & m.pwm & m.wide;
  endfunction

  function automatic logic irq_request(input mode_t m, input logic flag);
    return flag & m.match_en & m.irq_en;
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int TB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  output logic [TB_W-1:0] cnt_q,
  output logic [TB_W-1:0] cnt_nxt,
  output logic            wrap_evt
);
  localparam logic [TB_W-1:0] TOP = {TB_W{1'b1}};

  assign cnt_nxt  = cnt_q + 1'b1;
  assign wrap_evt = step && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_nxt;
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));
  // R2
  advance_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt_q == TB_W'($past(cnt_q) + 1'b1));

endmodule

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
  import pwm16_pkg::*;
#(
  parameter int TB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic            match_evt,
  output logic [TB_W-1:0] cmp_q,
  output mode_t           mode_q,
  output logic            flag_q
);
  localparam int HI_W = TB_W - 8;

  reg_sel_e sel;
  logic     wr_lo, wr_hi, wr_mode, clr_req;

  assign sel     = reg_sel_e'(wr_addr);
  assign wr_lo   = wr_en && (sel == REG_CMP_LO);
  assign wr_hi   = wr_en && (sel == REG_CMP_HI);
  assign wr_mode = wr_en && (sel == REG_MODE);
  assign clr_req = wr_en && (sel == REG_FLAG) && !wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      mode_q <= '0;
    end else if (wr_lo) begin
      cmp_q[7:0] <= wr_data;
      mode_q.en  <= 1'b0;
    end else if (wr_hi) begin
      cmp_q[TB_W-1:8] <= wr_data[HI_W-1:0];
      mode_q.en       <= 1'b1;
    end else if (wr_mode) begin
      mode_q <= mode_t'(wr_data[MODE_W-1:0]);
    end
  end

  // a match on the same edge outranks a clear
  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (match_evt) flag_q <= 1'b1;
    else if (clr_req)   flag_q <= 1'b0;
  end

  // R7
  lo_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> !mode_q.en);
  // R7
  hi_sets_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> mode_q.en);
  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag_q);
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_req |=> flag_q);

endmodule

// File: rtl/pwm_compare_out.sv
module pwm_compare_out #(
  parameter int TB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            active,
  input  logic [TB_W-1:0] cnt_nxt,
  input  logic [TB_W-1:0] cmp,
  input  logic            wrap_evt,
  output logic            match_evt,
  output logic            pwm_q
);
  assign match_evt = active && step && (cnt_nxt == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n)         pwm_q <= 1'b0;
    else if (match_evt) pwm_q <= 1'b1;
    else if (wrap_evt)  pwm_q <= 1'b0;
  end

  // R3
  set_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> pwm_q);
  // R4
  clear_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt && !match_evt |=> !pwm_q);
  // R4
  hold_between_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !match_evt && !wrap_evt |=> $stable(pwm_q));
  // R6
  no_match_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !match_evt);

endmodule

// File: rtl/pwm16_channel.sv
module pwm16_channel
  import pwm16_pkg::*;
#(
  parameter int TB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [7:0]      wr_data,
  output logic [TB_W-1:0] timebase,
  output logic            pwm_out,
  output logic            match_flag,
  output logic            cmp_enabled,
  output logic            match_irq
);
  logic [TB_W-1:0] cnt_nxt, cmp_q;
  logic            wrap_evt, match_evt, active;
  mode_t           mode_q;

  pwm_timebase #(.TB_W(TB_W)) u_timebase (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (tick_en),
    .cnt_q    (timebase),
    .cnt_nxt  (cnt_nxt),
    .wrap_evt (wrap_evt)
  );

  pwm_ctrl_regs #(.TB_W(TB_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .match_evt (match_evt),
    .cmp_q     (cmp_q),
    .mode_q    (mode_q),
    .flag_q    (match_flag)
  );

  assign active = mode_active(mode_q);

  pwm_compare_out #(.TB_W(TB_W)) u_compare (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (tick_en),
    .active    (active),
    .cnt_nxt   (cnt_nxt),
    .cmp       (cmp_q),
    .wrap_evt  (wrap_evt),
    .match_evt (match_evt),
    .pwm_q     (pwm_out)
  );

  assign cmp_enabled = mode_q.en;
  assign match_irq   = irq_request(mode_q, match_flag);

  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> match_flag);

endmodule

// File: tb/test_pwm16_channel.sv
module test_pwm16_channel;
  localparam int W   = 10;
  localparam int MAX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_on = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic [W-1:0] timebase;
  logic         pwm_out, match_flag, cmp_enabled, match_irq;

  int n_cmp = 0;
  int n_bad = 0;
  int hi_cnt = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  pwm16_channel #(.TB_W(W)) i_pwm16_channel (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_on),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .timebase    (timebase),
    .pwm_out     (pwm_out),
    .match_flag  (match_flag),
    .cmp_enabled (cmp_enabled),
    .match_irq   (match_irq)
  );

  task automatic check(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tb(input int v);
    do @(negedge clk); while (int'(timebase) != v);
  endtask

  // driver: load a compare value, then queue its expected high time
  task automatic run_period(input int cmpv);
    wait_tb(2);
    wr(2'd0, cmpv[7:0]);
    wr(2'd1, {6'd0, cmpv[9:8]});
    wait_tb(1);
    exp_q.push_back((1 << W) - cmpv);
    wait_tb(MAX);
  endtask

  // monitor: count high samples over one period, compare at its end
  always @(negedge clk) begin
    if (rst_n) begin
      if (timebase == '0) hi_cnt = int'(pwm_out);
      else                hi_cnt = hi_cnt + int'(pwm_out);
      if (int'(timebase) == MAX && exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        check("R5 high ticks per period", hi_cnt, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 timebase", int'(timebase), 0);
    check("R1 pwm_out", int'(pwm_out), 0);
    check("R1 match_flag", int'(match_flag), 0);
    check("R1 cmp_enabled", int'(cmp_enabled), 0);
    check("R1 match_irq", int'(match_irq), 0);

    // R2 gating by tick_en
    repeat (6) @(negedge clk);
    check("R2 idle timebase", int'(timebase), 0);
    tick_on = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 five ticks", int'(timebase), 5);
    tick_on = 1'b0;
    repeat (8) @(negedge clk);
    check("R2 held timebase", int'(timebase), 5);
    tick_on = 1'b1;

    // R7 byte-ordered writes toggle the enable
    wr(2'd2, 8'h1F);
    check("R7 mode write enable", int'(cmp_enabled), 1);
    wr(2'd0, 8'h34);
    check("R7 low write clears enable", int'(cmp_enabled), 0);
    wr(2'd1, 8'h01);
    check("R7 high write sets enable", int'(cmp_enabled), 1);

    // R5 / R3 / R4 sweep (0 checks match-wins at wrap)
    run_period(0);
    run_period(1);
    run_period(512);
    run_period(1000);
    run_period(MAX);

    // R8 lone low-byte write gives 0%
    wait_tb(2);
    wr(2'd0, 8'h00);
    check("R8 enable cleared", int'(cmp_enabled), 0);
    wait_tb(1);
    exp_q.push_back(0);
    wait_tb(MAX);

    // R6 PWM select off
    wait_tb(2);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h1D);
    wr(2'd3, 8'h00);
    wait_tb(1);
    exp_q.push_back(0);
    wait_tb(MAX);
    check("R6 no flag with PWM off", int'(match_flag), 0);
    // R6 wide select off
    wait_tb(2);
    wr(2'd2, 8'h1B);
    wait_tb(1);
    exp_q.push_back(0);
    wait_tb(MAX);
    check("R6 no flag with wide off", int'(match_flag), 0);

    // R9 / R10 flag and interrupt, compare 512
    wait_tb(2);
    wr(2'd2, 8'h0F);
    wait_tb(511);
    check("R3 low before match", int'(pwm_out), 0);
    @(negedge clk);
    check("R3 high at match", int'(pwm_out), 1);
    check("R9 flag set on match", int'(match_flag), 1);
    check("R10 irq off without irq enable", int'(match_irq), 0);
    wr(2'd3, 8'h01);
    check("R9 write of one keeps flag", int'(match_flag), 1);
    wr(2'd2, 8'h1F);
    check("R10 irq on with both enables", int'(match_irq), 1);
    wr(2'd2, 8'h17);
    check("R10 irq off without match enable", int'(match_irq), 0);
    wr(2'd3, 8'h00);
    check("R9 clear write", int'(match_flag), 0);
    wr(2'd2, 8'h1F);
    wait_tb(0);
    check("R4 low after wrap", int'(pwm_out), 0);
    // R9 set wins over a clear on the same edge
    wait_tb(511);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 set beats clear", int'(match_flag), 1);
    wr(2'd3, 8'h00);
    check("R9 clear without match", int'(match_flag), 0);

    @(negedge clk);
    check("R5 scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule